// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing part of a byte-addressed serial memory. It oversamples the SCL and SDA lines on the system clock, finds Start and Stop conditions, and shifts bytes in or out MSB first. Its only drive onto the bus is an open-drain pull-down enable for SDA. The block uses that enable to acknowledge bytes and to send read data.

A transaction opens with a select byte. The block accepts it only when the select byte holds the fixed code and the three strap bits, and only while the memory is not busy. In write mode, two word-address bytes follow the select byte, then any number of data bytes. Each data byte goes out on a one-cycle write strobe. In read mode, the block fetches bytes from an internal address pointer through a request/response port and continues for as long as the master acknowledges. A write-mode select followed by a repeated Start gives a random read. A read-mode select on its own reads from the address that follows the last byte accessed.

While the memory side reports a write cycle in progress, the block refuses every select byte. A host can therefore poll for completion by sending select bytes until one is acknowledged.

Top module: `twi_mem_slave`

## Requirements
- R1: A Start (SDA falls while SCL is high) at any point aborts the current transfer and begins reception of a new select byte. A Stop (SDA rises while SCL is high) releases SDA. After a Stop, bus activity is ignored until the next Start.
- R2: The select byte is laid out as follows: bits 7..4 = 1010, bits 3..1 = `strap_i[2:0]`, and bit 0 is the direction (1 = read). When the select byte matches, `sda_drive_o` is 1 throughout the ninth SCL clock.
- R3: If either the code nibble or the strap bits of a select byte differ, the block does not acknowledge. It then gives no acknowledge and makes no memory access until the next Start.
- R4: While `mem_busy_i` is 1, no select byte is acknowledged. Once `mem_busy_i` returns to 0, a matching select byte is acknowledged again.
- R5: In write mode, the select byte is followed by a high word-address byte and a low word-address byte, and every byte is acknowledged. Only the low ADDR_W-8 bits of the high byte are used. Each data byte produces one `wr_valid_o` pulse carrying the current address and the data.
- R6: After each data byte is written, the low PAGE_W address bits increment and wrap inside the page, and the upper address bits are held.
- R7: A random read is a write-mode select, the two address bytes, a repeated Start and a read-mode select. It returns the byte stored at the loaded address.
- R8: A read-mode select with no address phase returns the byte at the internal pointer. The pointer holds the last address read or written, plus one.
- R9: In a read, a master ACK (SDA low on the ninth clock) fetches the next address, wrapping from 2^ADDR_W-1 to 0. A master NACK ends the transfer with SDA released.
- R10: `sda_drive_o` only rises while the synchronized SCL is low.
- R11: After reset, `sda_drive_o`, `wr_valid_o` and `rd_req_o` are 0.
- R12: `wr_valid_o` and `rd_req_o` are single-cycle pulses. `rd_data_i` is sampled in the cycle after `rd_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired-AND value) |
| sda_drive_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap_i | input | 3 | Device strap bits, compared with select bits 3..1 |
| mem_busy_i | input | 1 | Memory internal write cycle in progress |
| wr_valid_o | output | 1 | Write strobe, one cycle per data byte |
| wr_addr_o | output | ADDR_W | Write address |
| wr_data_o | output | 8 | Write data |
| rd_req_o | output | 1 | Read request, one cycle |
| rd_addr_o | output | ADDR_W | Read address |
| rd_data_i | input | 8 | Read data, valid the cycle after `rd_req_o` |

## Verification
Each bus edge takes three clocks to reach a result: two synchronizer stages and one sequencer register. An acknowledge or data bit therefore appears on `sda_drive_o` three cycles after the SCL fall that precedes it, and `wr_valid_o` pulses three cycles after the SCL fall that ends the eighth data bit. A read fetch is issued at the fall that ends the select byte, or at the rise that samples the master ACK. The fetched byte is captured two cycles later, well before the next SCL fall loads it. The bench holds every quarter bit for six clocks and samples SDA in the middle of the SCL high phase, so all of these delays have settled before each sample.

// File: rtl/twi_pkg.sv
package twi_pkg;

    localparam logic [3:0] SEL_CODE = 4'b1010;
    localparam int         BYTE_W   = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEL,
        ST_ACK_SEL,
        ST_AHI,
        ST_ACK_AHI,
        ST_ALO,
        ST_ACK_ALO,
        ST_WDAT,
        ST_ACK_WDAT,
        ST_RDAT,
        ST_MACK
    } twi_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } twi_line_t;

    function automatic logic sel_hit(input logic [7:0] sel, input logic [2:0] strap);
        return (sel[7:4] == SEL_CODE) && (sel[3:1] == strap);
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    output twi_pkg::twi_line_t line_o
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_q;
    logic              sda_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= scl_i;
                    sda_sh <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= {scl_sh[STAGES-2:0], scl_i};
                    sda_sh <= {sda_sh[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_sh[TOP];
            sda_q <= sda_sh[TOP];
        end
    end

    always_comb begin
        line_o.scl   = scl_sh[TOP];
        line_o.sda   = sda_sh[TOP];
        line_o.start = scl_sh[TOP] & scl_q & sda_q & ~sda_sh[TOP];
        line_o.stop  = scl_sh[TOP] & scl_q & ~sda_q & sda_sh[TOP];
        line_o.rise  = scl_sh[TOP] & ~scl_q;
        line_o.fall  = ~scl_sh[TOP] & scl_q;
    end

endmodule

// File: rtl/twi_addr_ptr.sv
module twi_addr_ptr #(
    parameter int ADDR_W = 12,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              inc_page_i,
    input  logic              inc_full_i,
    output logic [ADDR_W-1:0] ptr_o
);
    logic [PAGE_W-1:0] page_next;

    assign page_next = ptr_o[PAGE_W-1:0] + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_o <= '0;
        end else if (load_i) begin
            ptr_o <= load_val_i;
        end else if (inc_page_i) begin
            ptr_o <= {ptr_o[ADDR_W-1:PAGE_W], page_next};
        end else if (inc_full_i) begin
            ptr_o <= ptr_o + 1'b1;
        end
    end

endmodule

// File: rtl/twi_proto_fsm.sv
module twi_proto_fsm #(
    parameter int ADDR_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  twi_pkg::twi_line_t line_i,
    input  logic [2:0]         strap_i,
    input  logic               mem_busy_i,
    input  logic [7:0]         rd_data_i,
    input  logic [ADDR_W-1:0]  ptr_i,
    output logic               sda_drive_o,
    output logic               wr_valid_o,
    output logic [ADDR_W-1:0]  wr_addr_o,
    output logic [7:0]         wr_data_o,
    output logic               rd_req_o,
    output logic [ADDR_W-1:0]  rd_addr_o,
    output logic               ptr_load_o,
    output logic [ADDR_W-1:0]  ptr_val_o,
    output logic               ptr_inc_page_o,
    output logic               ptr_inc_full_o
);
    import twi_pkg::*;

    localparam int         HI_W = ADDR_W - BYTE_W;
    localparam logic [3:0] LAST = 4'(BYTE_W);

    twi_state_e      state;
    logic [3:0]      cnt;
    logic [7:0]      shreg;
    logic [7:0]      txsh;
    logic [7:0]      rbuf;
    logic            rd_pend;
    logic [HI_W-1:0] hi_q;
    logic            rw;

    always_ff @(posedge clk) begin
        if (rst) begin
            state          <= ST_IDLE;
            cnt            <= '0;
            shreg          <= '0;
            txsh           <= '0;
            rbuf           <= '0;
            rd_pend        <= 1'b0;
            hi_q           <= '0;
            rw             <= 1'b0;
            sda_drive_o    <= 1'b0;
            wr_valid_o     <= 1'b0;
            wr_addr_o      <= '0;
            wr_data_o      <= '0;
            rd_req_o       <= 1'b0;
            rd_addr_o      <= '0;
            ptr_load_o     <= 1'b0;
            ptr_val_o      <= '0;
            ptr_inc_page_o <= 1'b0;
            ptr_inc_full_o <= 1'b0;
        end else begin
            wr_valid_o     <= 1'b0;
            rd_req_o       <= 1'b0;
            ptr_load_o     <= 1'b0;
            ptr_inc_page_o <= 1'b0;
            ptr_inc_full_o <= 1'b0;
            rd_pend        <= rd_req_o;
            if (rd_pend) begin
                rbuf <= rd_data_i;
            end

            if (line_i.start) begin
                state       <= ST_SEL;
                cnt         <= '0;
                sda_drive_o <= 1'b0;
            end else if (line_i.stop) begin
                state       <= ST_IDLE;
                cnt         <= '0;
                sda_drive_o <= 1'b0;
            end else begin
                case (state)
                    ST_SEL, ST_AHI, ST_ALO, ST_WDAT: begin
                        if (line_i.rise) begin
                            shreg <= {shreg[6:0], line_i.sda};
                            cnt   <= cnt + 1'b1;
                        end else if (line_i.fall && cnt == LAST) begin
                            cnt <= '0;
                            if (state == ST_SEL) begin
                                if (sel_hit(shreg, strap_i) && !mem_busy_i) begin
                                    sda_drive_o <= 1'b1;
                                    rw          <= shreg[0];
                                    state       <= ST_ACK_SEL;
                                    if (shreg[0]) begin
                                        rd_req_o       <= 1'b1;
                                        rd_addr_o      <= ptr_i;
                                        ptr_inc_full_o <= 1'b1;
                                    end
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_AHI) begin
                                hi_q        <= shreg[HI_W-1:0];
                                sda_drive_o <= 1'b1;
                                state       <= ST_ACK_AHI;
                            end else if (state == ST_ALO) begin
                                ptr_load_o  <= 1'b1;
                                ptr_val_o   <= {hi_q, shreg};
                                sda_drive_o <= 1'b1;
                                state       <= ST_ACK_ALO;
                            end else begin
                                wr_valid_o     <= 1'b1;
                                wr_addr_o      <= ptr_i;
                                wr_data_o      <= shreg;
                                ptr_inc_page_o <= 1'b1;
                                sda_drive_o    <= 1'b1;
                                state          <= ST_ACK_WDAT;
                            end
                        end
                    end
                    ST_ACK_SEL, ST_ACK_AHI, ST_ACK_ALO, ST_ACK_WDAT: begin
                        if (line_i.fall) begin
                            cnt         <= '0;
                            sda_drive_o <= 1'b0;
                            case (state)
                                ST_ACK_SEL: begin
                                    if (rw) begin
                                        state       <= ST_RDAT;
                                        txsh        <= rbuf;
                                        sda_drive_o <= ~rbuf[7];
                                    end else begin
                                        state <= ST_AHI;
                                    end
                                end
                                ST_ACK_AHI: state <= ST_ALO;
                                default:    state <= ST_WDAT;
                            endcase
                        end
                    end
                    ST_RDAT: begin
                        if (line_i.rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (line_i.fall) begin
                            if (cnt == LAST) begin
                                sda_drive_o <= 1'b0;
                                cnt         <= '0;
                                state       <= ST_MACK;
                            end else begin
                                txsh        <= {txsh[6:0], 1'b0};
                                sda_drive_o <= ~txsh[6];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (line_i.rise) begin
                            if (!line_i.sda) begin
                                cnt            <= 4'd1;
                                rd_req_o       <= 1'b1;
                                rd_addr_o      <= ptr_i;
                                ptr_inc_full_o <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (line_i.fall && cnt == 4'd1) begin
                            cnt         <= '0;
                            state       <= ST_RDAT;
                            txsh        <= rbuf;
                            sda_drive_o <= ~rbuf[7];
                        end
                    end
                    default: begin
                        cnt <= '0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
    parameter int ADDR_W      = 12,
    parameter int PAGE_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_drive_o,
    input  logic [2:0]        strap_i,
    input  logic              mem_busy_i,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i
);
    twi_pkg::twi_line_t line;
    logic [ADDR_W-1:0]  ptr;
    logic [ADDR_W-1:0]  ptr_val;
    logic               ptr_load;
    logic               ptr_inc_page;
    logic               ptr_inc_full;
    logic               scl_s;
    logic               start_s;
    logic               stop_s;

    assign scl_s   = line.scl;
    assign start_s = line.start;
    assign stop_s  = line.stop;

    twi_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_i),
        .sda_i  (sda_i),
        .line_o (line)
    );

    twi_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) ptr_i (
        .clk        (clk),
        .rst        (rst),
        .load_i     (ptr_load),
        .load_val_i (ptr_val),
        .inc_page_i (ptr_inc_page),
        .inc_full_i (ptr_inc_full),
        .ptr_o      (ptr)
    );

    twi_proto_fsm #(.ADDR_W(ADDR_W)) fsm_i (
        .clk            (clk),
        .rst            (rst),
        .line_i         (line),
        .strap_i        (strap_i),
        .mem_busy_i     (mem_busy_i),
        .rd_data_i      (rd_data_i),
        .ptr_i          (ptr),
        .sda_drive_o    (sda_drive_o),
        .wr_valid_o     (wr_valid_o),
        .wr_addr_o      (wr_addr_o),
        .wr_data_o      (wr_data_o),
        .rd_req_o       (rd_req_o),
        .rd_addr_o      (rd_addr_o),
        .ptr_load_o     (ptr_load),
        .ptr_val_o      (ptr_val),
        .ptr_inc_page_o (ptr_inc_page),
        .ptr_inc_full_o (ptr_inc_full)
    );

endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk (
    input logic clk,
    input logic rst,
    input logic scl_s,
    input logic start_s,
    input logic stop_s,
    input logic sda_drive_o,
    input logic wr_valid_o,
    input logic rd_req_o
);
    // R10: the pull-down only engages after a low SCL sample
    assert_drive_rise_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drive_o) |-> !$past(scl_s));

    // R12: strobes last one cycle
    assert_wr_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        wr_valid_o |=> !wr_valid_o);

    assert_rd_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        rd_req_o |=> !rd_req_o);

    // R1: stop releases the line
    assert_stop_release_R1: assert property (@(posedge clk) disable iff (rst)
        stop_s |=> !sda_drive_o);

    // R1: start releases the line and writes nothing
    assert_start_abort_R1: assert property (@(posedge clk) disable iff (rst)
        start_s |=> (!sda_drive_o && !wr_valid_o));

endmodule

bind twi_mem_slave twi_mem_slave_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .scl_s       (scl_s),
    .start_s     (start_s),
    .stop_s      (stop_s),
    .sda_drive_o (sda_drive_o),
    .wr_valid_o  (wr_valid_o),
    .rd_req_o    (rd_req_o)
);

// File: tb/twi_mem_slave_tb_top.sv
module twi_mem_slave_tb_top;
    localparam int AW = 10;
    localparam int PW = 5;
    localparam int Q  = 6;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          scl_m = 1'b1;
    logic          sda_m = 1'b1;
    logic [2:0]    strap = 3'b101;
    logic          busy  = 1'b0;
    logic          sda_drive;
    logic          wr_valid;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data = 8'h00;
    logic          sda_bus;

    assign sda_bus = sda_m & ~sda_drive;

    twi_mem_slave #(.ADDR_W(AW), .PAGE_W(PW), .SYNC_STAGES(2)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_m),
        .sda_i       (sda_bus),
        .sda_drive_o (sda_drive),
        .strap_i     (strap),
        .mem_busy_i  (busy),
        .wr_valid_o  (wr_valid),
        .wr_addr_o   (wr_addr),
        .wr_data_o   (wr_data),
        .rd_req_o    (rd_req),
        .rd_addr_o   (rd_addr),
        .rd_data_i   (rd_data)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) % 256);
    endfunction

    // memory model
    logic [7:0] mem [0:DEPTH-1];
    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = pat(i);
    end
    always @(posedge clk) begin
        if (wr_valid) mem[wr_addr] <= wr_data;
        if (rd_req)   rd_data <= mem[rd_addr];
    end

    // monitors
    int   wr_cnt = 0;
    int   wr_log_a [0:15];
    int   wr_log_d [0:15];
    int   pulse_err = 0;
    int   rise_err = 0;
    logic wr_prev = 1'b0;
    logic rd_prev = 1'b0;
    logic drv_prev = 1'b0;
    always @(posedge clk) begin
        if (!rst) begin
            if (wr_valid) begin
                if (wr_cnt < 16) begin
                    wr_log_a[wr_cnt] = int'(wr_addr);
                    wr_log_d[wr_cnt] = int'(wr_data);
                end
                wr_cnt = wr_cnt + 1;
            end
            if ((wr_valid && wr_prev) || (rd_req && rd_prev)) pulse_err = pulse_err + 1;
            if (sda_drive && !drv_prev && scl_m) rise_err = rise_err + 1;
        end
        wr_prev  = wr_valid;
        rd_prev  = rd_req;
        drv_prev = sda_drive;
    end

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic chk(input string req, input int act, input int exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic wbit(input bit b);
        sda_m = b;    wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic rbit(output bit b);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        b = sda_bus;  wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic send(input logic [7:0] v, output bit ack);
        bit x;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(x);
        ack = !x;
    endtask

    task automatic recv(output logic [7:0] v, input bit mack);
        bit x;
        for (int i = 7; i >= 0; i--) begin
            rbit(x);
            v[i] = x;
        end
        wbit(!mack);
    endtask

    function automatic logic [7:0] sel(input bit rd);
        return {4'b1010, strap, rd};
    endfunction

    // write select plus word address; leaves SCL low
    task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, output int acks);
        bit a;
        acks = 0;
        bus_start();
        send(sel(1'b0), a); acks += int'(a);
        send(hi, a);        acks += int'(a);
        send(lo, a);        acks += int'(a);
    endtask

    task automatic rd_start(output bit a);
        bus_start();
        send(sel(1'b1), a);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        bit          a;
        int          acks;
        int          wbase;
        logic [7:0]  d;

        repeat (10) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 drive", int'(sda_drive), 0);
        chk("R11 wr_valid", int'(wr_valid), 0);
        chk("R11 rd_req", int'(rd_req), 0);
        wq();

        // R2 / R3 sweep over strap bits in the select byte
        for (int s = 0; s < 8; s++) begin
            bus_start();
            send({4'b1010, 3'(s), 1'b0}, a);
            chk((s == int'(strap)) ? "R2 strap match" : "R3 strap mismatch",
                int'(a), (s == int'(strap)) ? 1 : 0);
            bus_stop();
        end
        // R2 / R3 sweep over the code nibble
        for (int c = 0; c < 16; c++) begin
            bus_start();
            send({4'(c), strap, 1'b1}, a);
            chk((c == 10) ? "R2 code match" : "R3 code mismatch",
                int'(a), (c == 10) ? 1 : 0);
            if (c == 10) begin
                recv(d, 1'b0);
            end
            bus_stop();
        end

        // R3: rejected select leaves later bytes ignored
        wbase = wr_cnt;
        bus_start();
        send(8'hB0 | {4'b0, strap, 1'b0}, a);
        chk("R3 bad code nack", int'(a), 0);
        send(8'h00, a);
        chk("R3 follow-on ignored", int'(a), 0);
        send(8'h10, a);
        send(8'h77, a);
        bus_stop();
        chk("R3 no write", wr_cnt - wbase, 0);

        // R5 byte write, upper address bits ignored
        wbase = wr_cnt;
        set_addr(8'hF1, 8'h23, acks);
        send(8'h5A, a);
        bus_stop();
        chk("R5 acks", acks + int'(a), 4);
        chk("R5 one strobe", wr_cnt - wbase, 1);
        chk("R5 addr", wr_log_a[wbase], 'h123);
        chk("R5 data", wr_log_d[wbase], 'h5A);

        // R6 page write wraps inside the page
        wbase = wr_cnt;
        set_addr(8'h00, 8'h3E, acks);
        send(8'hA1, a); send(8'hA2, a); send(8'hA3, a);
        bus_stop();
        chk("R6 strobes", wr_cnt - wbase, 3);
        chk("R6 addr0", wr_log_a[wbase],     'h03E);
        chk("R6 addr1", wr_log_a[wbase + 1], 'h03F);
        chk("R6 addr2 wrap", wr_log_a[wbase + 2], 'h020);
        chk("R6 data2", wr_log_d[wbase + 2], 'hA3);

        // R8 current address read after a write: last written 0x020 -> 0x021
        rd_start(a);
        recv(d, 1'b0);
        bus_stop();
        chk("R8 ack", int'(a), 1);
        chk("R8 data after write", int'(d), int'(pat('h021)));

        // R7 random reads
        set_addr(8'h01, 8'h23, acks);
        rd_start(a);
        recv(d, 1'b0);
        bus_stop();
        chk("R7 acks", acks + int'(a), 4);
        chk("R7 data 0x123", int'(d), 'h5A);
        set_addr(8'h00, 8'h20, acks);
        rd_start(a);
        recv(d, 1'b0);
        bus_stop();
        chk("R7 data 0x020", int'(d), 'hA3);

        // R9 sequential read across the top of memory
        set_addr(8'h03, 8'hFE, acks);
        rd_start(a);
        recv(d, 1'b1);
        chk("R9 seq 0x3FE", int'(d), int'(pat('h3FE)));
        recv(d, 1'b1);
        chk("R9 seq 0x3FF", int'(d), int'(pat('h3FF)));
        recv(d, 1'b1);
        chk("R9 seq wrap 0x000", int'(d), int'(pat('h000)));
        recv(d, 1'b0);
        chk("R9 seq 0x001", int'(d), int'(pat('h001)));
        wq();
        chk("R9 released after nack", int'(sda_drive), 0);
        bus_stop();
        // R8: pointer is last read + 1
        rd_start(a);
        recv(d, 1'b0);
        bus_stop();
        chk("R8 data after read", int'(d), int'(pat('h002)));

        // R4 busy refuses selects, then polling succeeds
        wbase = wr_cnt;
        busy = 1'b1;
        bus_start();
        send(sel(1'b0), a);
        chk("R4 busy nack", int'(a), 0);
        send(8'h00, a);
        chk("R4 busy ignored", int'(a), 0);
        bus_stop();
        bus_start();
        send(sel(1'b1), a);
        chk("R4 busy read nack", int'(a), 0);
        bus_stop();
        busy = 1'b0;
        wq();
        bus_start();
        send(sel(1'b0), a);
        chk("R4 poll ack", int'(a), 1);
        bus_stop();
        chk("R4 no write", wr_cnt - wbase, 0);

        // R1 repeated start mid-byte aborts; pointer unchanged (0x003)
        bus_start();
        send(sel(1'b0), a);
        wbit(1'b0); wbit(1'b1); wbit(1'b1); wbit(1'b0);
        rd_start(a);
        chk("R1 select after abort", int'(a), 1);
        recv(d, 1'b0);
        bus_stop();
        chk("R1 data after abort", int'(d), int'(pat('h003)));

        // R1 stop mid-byte; later bits without start are ignored
        wbase = wr_cnt;
        set_addr(8'h00, 8'h40, acks);
        wbit(1'b1); wbit(1'b1); wbit(1'b0); wbit(1'b0);
        bus_stop();
        send(8'h99, a);
        chk("R1 ignored after stop", int'(a), 0);
        bus_stop();
        chk("R1 no write after stop", wr_cnt - wbase, 0);
        set_addr(8'h00, 8'h40, acks);
        rd_start(a);
        recv(d, 1'b0);
        bus_stop();
        chk("R1 memory untouched", int'(d), int'(pat('h040)));

        // R12 / R10 from the monitors
        chk("R12 pulse width", pulse_err, 0);
        chk("R10 drive rise while SCL high", rise_err, 0);

        done = 1'b1;
        summary();
    end

endmodule